// File: doc/BRIEF.md
# Multi-Mode SPI Master Serial Engine

This block is the serial core of an SPI master. It takes words from an external transmit FIFO through a valid/pop handshake and shifts them out on MOSI, most significant bit first. It hands the words it receives to an external receive FIFO through a push strobe. The frame length, SCLK polarity and phase, and the SCLK divider are configuration inputs, and so is a loopback switch that feeds the outgoing serial bit back into the receiver in place of MISO.

There are four transfer modes. Full duplex sends and receives every frame. Transmit-only sends and discards what comes back. Receive-only is started by one queued word, which is discarded, and then reads a programmed number of frames. EEPROM read first sends all queued words (for example a command and an address) and then reads a programmed number of frames. In both reading modes MOSI is held low while frames are read.

A transfer keeps the selected slave-select lines low for as long as frames follow each other without a gap. The selection mask is captured when a transfer starts. Dropping the enable input aborts at once and holds the external FIFOs in their clear state.

Top module: `spi_xfer_engine`

## Requirements
- R1: A frame is `cfg_size_m1 + 1` bits long, and size values below 3 act as 3 (4 bits). MOSI carries the low bits of the transmit word, MSB first. `rx_data` holds the received bits right-justified, with the upper bits zero.
- R2: Mode 0 (full duplex): each popped word produces one frame, and each frame pushes one received word.
- R3: Mode 1 (transmit only): frames are sent as in mode 0, and `rx_push` never goes high.
- R4: Mode 2 (receive only): one queued word is popped and not sent. Then exactly `cfg_frames_m1 + 1` frames are read with MOSI low, each pushing one word. A count of 0 reads exactly one frame.
- R5: Mode 3 (EEPROM read): every queued word is sent first, with no push. Then `cfg_frames_m1 + 1` frames are read with MOSI low, each pushing one word.
- R6: Each SCLK half period lasts `cfg_div / 2` clock cycles (bit 0 of the divider is ignored). A divider of 0 freezes SCLK and stalls the transfer.
- R7: SCLK rests at `cfg_cpol` while idle and between frames. With `cfg_cpha = 0` the data is sampled on the first edge of each bit. With `cfg_cpha = 1` it is sampled on the second edge.
- R8: In modes 0, 1 and 3, the next frame follows if the transmit FIFO is non-empty at the end of a frame, and the slave select stays low. When the FIFO is empty at a frame end, the sending phase ends.
- R9: `ss_n` is all ones while idle. At the start of a transfer it becomes `~cfg_ss_mask`. Changes to the mask while idle or during a transfer do not move the lines.
- R10: With `cfg_loopback = 1` the receiver takes the MOSI bit instead of MISO, so in full duplex each received word equals the sent word, masked to the frame length.
- R11: While `en` is low, `fifo_clear` is high, nothing starts, and one cycle after `en` falls `busy` is low, `ss_n` is all ones and SCLK is at rest.
- R12: `busy` is high from the cycle the slave select asserts until the cycle after the last SCLK edge of the final frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Engine enable; low aborts and clears |
| cfg_mode | input | 2 | 0 duplex, 1 transmit only, 2 receive only, 3 EEPROM read |
| cfg_size_m1 | input | SIZE_W | Frame length minus one |
| cfg_cpol | input | 1 | SCLK resting level |
| cfg_cpha | input | 1 | 0: sample on first edge, 1: on second edge |
| cfg_loopback | input | 1 | Route MOSI to the receiver |
| cfg_div | input | DIV_W | SCLK divider (even, 0 stops) |
| cfg_frames_m1 | input | CNT_W | Frames to read minus one |
| cfg_ss_mask | input | NSS | Slave select enable mask |
| tx_valid | input | 1 | Transmit FIFO not empty |
| tx_data | input | DATA_W | Transmit FIFO head word |
| tx_pop | output | 1 | Take the head word this cycle |
| rx_push | output | 1 | Write `rx_data` to the receive FIFO |
| rx_data | output | DATA_W | Received word, right-justified |
| fifo_clear | output | 1 | Hold both FIFOs empty |
| miso | input | 1 | Serial data from the slave |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| ss_n | output | NSS | Active-low slave selects |
| busy | output | 1 | Transfer in progress |

## Verification
The bench uses the default parameters: 16-bit words, a 4-bit size field, a 16-bit divider, a 12-bit frame count and four selects. This lets it cover frame lengths from the clamped 4 bits up to the full 16, every mode and every polarity and phase pairing against a behavioural slave. With the wide divider the bench can run a slow divider of 8 and measure its 4-cycle half period, and it can also use the stopped divider of 0. The 12-bit count covers the one-frame corner of the reading modes. The four selects let a mask change during a transfer show up as a distinct pattern.

// File: rtl/spi_xfer_pkg.sv
// Package: shared encodings for the SPI master engine.
// Assumes: mode codes are fixed by the configuration interface.
package spi_xfer_pkg;
    typedef enum logic [1:0] {
        MODE_DUPLEX    = 2'd0,
        MODE_TX_ONLY   = 2'd1,
        MODE_RX_ONLY   = 2'd2,
        MODE_EEPROM_RD = 2'd3
    } xfer_mode_e;

    typedef enum logic [1:0] {
        CTL_IDLE = 2'd0,
        CTL_SEND = 2'd1,
        CTL_RECV = 2'd2
    } ctl_state_e;

    localparam int unsigned MIN_FRAME_M1 = 3;
endpackage

// File: rtl/spi_baud_gen.sv
// Module: SCLK half-period tick generator.
// Emits one tick every div/2 cycles while run is high; restarts when run
// drops. A divider below 2 gives no ticks. Assumes div is static while run.
module spi_baud_gen #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    localparam int HALF_W = DIV_W - 1;

    logic [HALF_W-1:0] half;
    logic [HALF_W-1:0] cnt;

    assign half = div[DIV_W-1:1];
    assign tick = run && (half != '0) && (cnt >= half - 1'b1);

    // Count cycles within the current half period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || half == '0 || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R6: with a half period of two or more cycles, ticks never come back to back
    assert_tick_spacing_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && half >= 2 && run) |=> !tick);
endmodule

// File: rtl/spi_frame_shifter.sv
// Module: one-frame shift engine.
// On load it captures a word (or zeros when muted) left-aligned to the frame
// length, then on each tick toggles SCLK and shifts or samples according to
// phase. done pulses one cycle after the last edge. Assumes load only while
// not active, and cpol/cpha/loopback static during a frame.
module spi_frame_shifter
    import spi_xfer_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int SIZE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              abort,
    input  logic              load,
    input  logic [DATA_W-1:0] load_word,
    input  logic              mute,
    input  logic [SIZE_W-1:0] size_m1,
    input  logic              cpol,
    input  logic              cpha,
    input  logic              loopback,
    input  logic              miso,
    input  logic              tick,
    output logic              active,
    output logic              sclk,
    output logic              mosi,
    output logic              done,
    output logic [DATA_W-1:0] rx_word
);
    localparam int HC_W = SIZE_W + 1;

    logic [DATA_W-1:0] tx_sh;
    logic [DATA_W-1:0] rx_sh;
    logic [HC_W-1:0]   hcnt;
    logic [SIZE_W-1:0] nb_q;
    logic [SIZE_W-1:0] eff_m1;
    logic              sph;
    logic              leading;
    logic              do_sample;
    logic              do_shift;
    logic              rx_in;

    assign eff_m1    = (size_m1 < SIZE_W'(MIN_FRAME_M1)) ? SIZE_W'(MIN_FRAME_M1) : size_m1;
    assign leading   = ~hcnt[0];
    assign do_sample = active && tick && (cpha ? !leading : leading);
    assign do_shift  = active && tick && (cpha ? (leading && hcnt != '0) : !leading);
    assign mosi      = tx_sh[DATA_W-1];
    assign rx_in     = loopback ? mosi : miso;
    assign sclk      = cpol ^ sph;
    assign rx_word   = rx_sh;

    // Frame sequencing: load, per-tick edge handling, end-of-frame pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sh  <= '0;
            rx_sh  <= '0;
            hcnt   <= '0;
            nb_q   <= '0;
            sph    <= 1'b0;
            active <= 1'b0;
            done   <= 1'b0;
        end else if (abort) begin
            sph    <= 1'b0;
            active <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (load) begin
                tx_sh  <= mute ? '0 : (load_word << (DATA_W - 1 - int'(eff_m1)));
                rx_sh  <= '0;
                hcnt   <= '0;
                nb_q   <= eff_m1;
                sph    <= 1'b0;
                active <= 1'b1;
            end else if (active && tick) begin
                sph <= ~sph;
                if (do_sample) rx_sh <= {rx_sh[DATA_W-2:0], rx_in};
                if (do_shift)  tx_sh <= tx_sh << 1;
                if (hcnt == {nb_q, 1'b1}) begin
                    active <= 1'b0;
                    done   <= 1'b1;
                end
                hcnt <= hcnt + 1'b1;
            end
        end
    end

    // R7: every frame ends with SCLK back at its resting level
    assert_frame_rest_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (sclk == cpol));
    // R8: a new frame is never loaded on top of a running one
    assert_load_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !active);
endmodule

// File: rtl/spi_xfer_engine.sv
// Module: SPI master transfer engine (top).
// Sequences frames across the four transfer modes, owns the slave selects
// and the FIFO handshakes. Assumes configuration inputs are static while
// busy, and the FIFOs are external (valid/pop and push interfaces).
module spi_xfer_engine
    import spi_xfer_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int SIZE_W = 4,
    parameter int DIV_W  = 16,
    parameter int CNT_W  = 12,
    parameter int NSS    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [1:0]        cfg_mode,
    input  logic [SIZE_W-1:0] cfg_size_m1,
    input  logic              cfg_cpol,
    input  logic              cfg_cpha,
    input  logic              cfg_loopback,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic [CNT_W-1:0]  cfg_frames_m1,
    input  logic [NSS-1:0]    cfg_ss_mask,
    input  logic              tx_valid,
    input  logic [DATA_W-1:0] tx_data,
    output logic              tx_pop,
    output logic              rx_push,
    output logic [DATA_W-1:0] rx_data,
    output logic              fifo_clear,
    input  logic              miso,
    output logic              sclk,
    output logic              mosi,
    output logic [NSS-1:0]    ss_n,
    output logic              busy
);
    localparam logic [NSS-1:0] SS_NONE = {NSS{1'b1}};

    ctl_state_e       state, nxt_state;
    xfer_mode_e       mode_q, nxt_mode;
    logic [CNT_W-1:0] rx_left, nxt_left;
    logic             cur_rx, nxt_rx;
    logic             ld, ld_mute;
    logic             sh_active, sh_done, tick;

    assign busy       = (state != CTL_IDLE);
    assign fifo_clear = !en;
    assign rx_push    = en && sh_done && cur_rx;

    spi_baud_gen #(.DIV_W(DIV_W)) u_baud (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (sh_active),
        .div   (cfg_div),
        .tick  (tick)
    );

    spi_frame_shifter #(.DATA_W(DATA_W), .SIZE_W(SIZE_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .abort     (!en),
        .load      (ld),
        .load_word (tx_data),
        .mute      (ld_mute),
        .size_m1   (cfg_size_m1),
        .cpol      (cfg_cpol),
        .cpha      (cfg_cpha),
        .loopback  (cfg_loopback),
        .miso      (miso),
        .tick      (tick),
        .active    (sh_active),
        .sclk      (sclk),
        .mosi      (mosi),
        .done      (sh_done),
        .rx_word   (rx_data)
    );

    // Next-frame decision per state and mode.
    always_comb begin
        nxt_state = state;
        nxt_mode  = mode_q;
        nxt_left  = rx_left;
        nxt_rx    = cur_rx;
        tx_pop    = 1'b0;
        ld        = 1'b0;
        ld_mute   = 1'b0;
        case (state)
            CTL_IDLE: begin
                if (tx_valid) begin
                    tx_pop   = 1'b1;
                    ld       = 1'b1;
                    nxt_mode = xfer_mode_e'(cfg_mode);
                    if (nxt_mode == MODE_RX_ONLY) begin
                        ld_mute   = 1'b1;
                        nxt_state = CTL_RECV;
                        nxt_left  = cfg_frames_m1;
                        nxt_rx    = 1'b1;
                    end else begin
                        nxt_state = CTL_SEND;
                        nxt_rx    = (nxt_mode == MODE_DUPLEX);
                    end
                end
            end
            CTL_SEND: begin
                if (sh_done) begin
                    if (tx_valid) begin
                        tx_pop = 1'b1;
                        ld     = 1'b1;
                    end else if (mode_q == MODE_EEPROM_RD) begin
                        ld        = 1'b1;
                        ld_mute   = 1'b1;
                        nxt_state = CTL_RECV;
                        nxt_left  = cfg_frames_m1;
                        nxt_rx    = 1'b1;
                    end else begin
                        nxt_state = CTL_IDLE;
                    end
                end
            end
            CTL_RECV: begin
                if (sh_done) begin
                    if (rx_left != '0) begin
                        ld       = 1'b1;
                        ld_mute  = 1'b1;
                        nxt_left = rx_left - 1'b1;
                    end else begin
                        nxt_state = CTL_IDLE;
                    end
                end
            end
            default: nxt_state = CTL_IDLE;
        endcase
        if (!en) begin
            tx_pop = 1'b0;
            ld     = 1'b0;
        end
    end

    // Control state, latched mode, frame countdown and slave-select lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= CTL_IDLE;
            mode_q  <= MODE_DUPLEX;
            rx_left <= '0;
            cur_rx  <= 1'b0;
            ss_n    <= SS_NONE;
        end else if (!en) begin
            state <= CTL_IDLE;
            ss_n  <= SS_NONE;
        end else begin
            state   <= nxt_state;
            mode_q  <= nxt_mode;
            rx_left <= nxt_left;
            cur_rx  <= nxt_rx;
            if (state == CTL_IDLE && nxt_state != CTL_IDLE) begin
                ss_n <= ~cfg_ss_mask;
            end else if (nxt_state == CTL_IDLE) begin
                ss_n <= SS_NONE;
            end
        end
    end

    // R9: no select is driven while idle
    assert_ss_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (ss_n == SS_NONE));
    // R8: selects hold steady for the whole transfer
    assert_ss_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(ss_n));
    // R11: disabling aborts within one cycle
    assert_abort_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!busy && ss_n == SS_NONE));
    // R6: a zero divider freezes SCLK
    assert_div_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cfg_div == '0 && $past(busy && cfg_div == '0)) |-> $stable(sclk));
    // R4: reading phases drive MOSI low
    assert_read_mosi_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cur_rx && (mode_q == MODE_RX_ONLY || mode_q == MODE_EEPROM_RD)) |-> !mosi);
    // R3: transmit-only never pushes
    assert_txonly_no_push_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && mode_q == MODE_TX_ONLY) |-> !rx_push);
    // R12: a running frame implies busy
    assert_busy_cover_R12: assert property (@(posedge clk) disable iff (!rst_n)
        sh_active |-> busy);
endmodule

// File: tb/tb_spi_xfer_engine.sv
`timescale 1ns/1ps
module tb_spi_xfer_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [1:0]  cfg_mode = 2'd0;
    logic [3:0]  cfg_size_m1 = 4'd7;
    logic        cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_loopback = 1'b0;
    logic [15:0] cfg_div = 16'd2;
    logic [11:0] cfg_frames_m1 = '0;
    logic [3:0]  cfg_ss_mask = 4'b0001;
    logic        tx_valid, tx_pop, rx_push, fifo_clear, miso, sclk, mosi, busy;
    logic [15:0] tx_data, rx_data;
    logic [3:0]  ss_n;

    always #10 clk = ~clk;  // 50 MHz

    spi_xfer_engine dut (
        .clk(clk), .rst_n(rst_n), .en(en), .cfg_mode(cfg_mode),
        .cfg_size_m1(cfg_size_m1), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
        .cfg_loopback(cfg_loopback), .cfg_div(cfg_div),
        .cfg_frames_m1(cfg_frames_m1), .cfg_ss_mask(cfg_ss_mask),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_pop(tx_pop),
        .rx_push(rx_push), .rx_data(rx_data), .fifo_clear(fifo_clear),
        .miso(miso), .sclk(sclk), .mosi(mosi), .ss_n(ss_n), .busy(busy)
    );

    int errors = 0;
    int checks = 0;
    int cyc = 0;

    // Transmit FIFO model: written by the stimulus, drained by pops/clears.
    logic [15:0] tx_q [0:15];
    int tx_wr = 0;
    int tx_rd = 0;
    assign tx_valid = (tx_rd != tx_wr);
    assign tx_data  = tx_q[tx_rd % 16];
    always @(posedge clk) begin
        if (fifo_clear) tx_rd <= tx_wr;
        else if (tx_pop) tx_rd <= tx_rd + 1;
    end

    // Receive log.
    logic [15:0] rx_got [0:255];
    int rx_n = 0;
    always @(posedge clk) if (rx_push) begin
        rx_got[rx_n % 256] <= rx_data;
        rx_n <= rx_n + 1;
    end

    // Behavioural slave: captures MOSI, answers on MISO.
    logic [15:0] slv_word = '0;
    int n_bits = 8;
    int slv_idx = 0;
    logic [15:0] slv_cap = '0;
    logic [15:0] slv_got [0:255];
    int slv_n = 0;
    int ss_falls = 0;
    int sclk_edges = 0;
    logic [3:0] prev_ss = 4'hF;
    logic prev_sclk = 1'b0;
    time t_last = 0, t_gap = 0;
    assign miso = (ss_n != 4'hF) ? slv_word[n_bits - 1 - slv_idx] : 1'b0;
    always @(sclk, ss_n) begin
        if (ss_n != prev_ss) begin
            if (prev_ss == 4'hF) ss_falls++;
            slv_idx = 0;
            slv_cap = '0;
            prev_ss = ss_n;
        end
        if (sclk != prev_sclk) begin
            prev_sclk = sclk;
            if (ss_n != 4'hF) begin
                sclk_edges++;
                t_gap  = $time - t_last;
                t_last = $time;
                if (cfg_cpha ? (sclk == cfg_cpol) : (sclk != cfg_cpol)) begin
                    slv_cap = {slv_cap[14:0], mosi};
                    slv_idx++;
                    if (slv_idx == n_bits) begin
                        slv_got[slv_n % 256] = slv_cap;
                        slv_n++;
                        slv_idx = 0;
                        slv_cap = '0;
                    end
                end
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors + 1, checks + 1);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_busy(input logic lvl);
        int n = 0;
        while (busy !== lvl && n < 20000) begin
            @(negedge clk);
            n++;
        end
    endtask

    typedef struct packed {
        logic [1:0]  mode;
        logic [3:0]  sz;
        logic        cpol;
        logic        cpha;
        logic        lpb;
        logic [15:0] div;
        logic [2:0]  nw;
        logic [15:0] base;
        logic [15:0] slv;
        logic [11:0] fm1;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 4'd7,  1'b0, 1'b0, 1'b0, 16'd2, 3'd2, 16'hA5C3, 16'h3C96, 12'd0},
        '{2'd0, 4'd15, 1'b1, 1'b1, 1'b0, 16'd4, 3'd1, 16'hBEEF, 16'h1234, 12'd0},
        '{2'd1, 4'd3,  1'b0, 1'b1, 1'b0, 16'd2, 3'd3, 16'h0009, 16'h0005, 12'd0},
        '{2'd2, 4'd11, 1'b1, 1'b0, 1'b0, 16'd2, 3'd1, 16'h0FFF, 16'h0ABC, 12'd2},
        '{2'd3, 4'd7,  1'b0, 1'b0, 1'b0, 16'd2, 3'd2, 16'h0310, 16'h005A, 12'd1},
        '{2'd0, 4'd9,  1'b1, 1'b0, 1'b1, 16'd2, 3'd2, 16'h1357, 16'h0000, 12'd0},
        '{2'd2, 4'd4,  1'b0, 1'b1, 1'b0, 16'd2, 3'd1, 16'h0001, 16'h0013, 12'd0},
        '{2'd0, 4'd1,  1'b0, 1'b0, 1'b0, 16'd2, 3'd1, 16'h00AD, 16'h000A, 12'd0}
    };

    function automatic logic [15:0] word_of(input vec_t v, input int i);
        return v.base + 16'(i) * 16'h1111;
    endfunction

    task automatic push_words(input vec_t v);
        for (int i = 0; i < int'(v.nw); i++) tx_q[(tx_wr + i) % 16] = word_of(v, i);
        tx_wr = tx_wr + int'(v.nw);
    endtask

    task automatic run_vec(input vec_t v);
        int nb, mk, rxb, sb, fb, nrx, nsl, ntx;
        string mtag;
        @(negedge clk);
        cfg_mode = v.mode; cfg_size_m1 = v.sz; cfg_cpol = v.cpol; cfg_cpha = v.cpha;
        cfg_loopback = v.lpb; cfg_div = v.div; cfg_frames_m1 = v.fm1;
        nb = (v.sz < 3) ? 4 : int'(v.sz) + 1;
        n_bits = nb;
        slv_word = v.slv;
        mk = (1 << nb) - 1;
        @(negedge clk);
        rxb = rx_n; sb = slv_n; fb = ss_falls;
        push_words(v);
        wait_busy(1'b1);
        wait_busy(1'b0);
        repeat (2) @(negedge clk);
        case (v.mode)
            2'd0: begin mtag = v.lpb ? "R10" : "R2"; nrx = v.nw; ntx = v.nw; nsl = v.nw; end
            2'd1: begin mtag = "R3"; nrx = 0; ntx = v.nw; nsl = v.nw; end
            2'd2: begin mtag = "R4"; nrx = v.fm1 + 1; ntx = 0; nsl = v.fm1 + 1; end
            default: begin mtag = "R5"; nrx = v.fm1 + 1; ntx = v.nw; nsl = v.nw + v.fm1 + 1; end
        endcase
        chk({mtag, " rx count"}, rx_n - rxb, nrx);
        chk({mtag, " slave frame count"}, slv_n - sb, nsl);
        for (int k = 0; k < nrx && k < rx_n - rxb; k++) begin
            int exp_rx;
            if (v.mode == 2'd0) exp_rx = v.lpb ? (int'(word_of(v, k)) & mk) : (int'(v.slv) & mk);
            else exp_rx = v.lpb ? 0 : (int'(v.slv) & mk);
            chk({mtag, " R1 rx word"}, int'(rx_got[(rxb + k) % 256]), exp_rx);
        end
        for (int k = 0; k < nsl && k < slv_n - sb; k++) begin
            int exp_tx = (k < ntx) ? (int'(word_of(v, k)) & mk) : 0;
            chk({mtag, " R1 mosi word"}, int'(slv_got[(sb + k) % 256]), exp_tx);
        end
        chk("R8 single select session", ss_falls - fb, 1);
        chk("R8 tx fifo drained", tx_wr - tx_rd, 0);
        chk("R7 sclk rest level", int'(sclk), int'(v.cpol));
        chk("R12 busy low after end", int'(busy), 0);
        chk("R9 selects released", int'(ss_n), 15);
    endtask

    initial begin
        int e0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state.
        chk("R12 busy after reset", int'(busy), 0);
        chk("R9 ss_n after reset", int'(ss_n), 15);
        chk("R7 sclk after reset", int'(sclk), 0);
        chk("R11 fifo_clear while disabled", int'(fifo_clear), 1);
        en = 1'b1;
        @(negedge clk);
        chk("R11 fifo_clear when enabled", int'(fifo_clear), 0);

        // Table-driven transfers.
        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R9 mask latching and R6 half period.
        cfg_mode = 2'd1; cfg_size_m1 = 4'd15; cfg_cpol = 1'b0; cfg_cpha = 1'b0;
        cfg_loopback = 1'b0; cfg_div = 16'd8; n_bits = 16;
        cfg_ss_mask = 4'b0110;
        repeat (3) @(negedge clk);
        chk("R9 idle mask change ignored", int'(ss_n), 15);
        tx_q[tx_wr % 16] = 16'h8001; tx_wr = tx_wr + 1;
        wait_busy(1'b1);
        chk("R9 mask applied at start", int'(ss_n), 4'b1001);
        cfg_ss_mask = 4'b1111;
        repeat (20) @(negedge clk);
        chk("R9 mid-transfer mask change ignored", int'(ss_n), 4'b1001);
        chk("R6 half period for divider 8 (ns)", int'(t_gap), 80);
        chk("R12 busy during frame", int'(busy), 1);
        wait_busy(1'b0);
        @(negedge clk);
        chk("R9 released after transfer", int'(ss_n), 15);
        cfg_ss_mask = 4'b0001;

        // R6 divider 0 stalls, then R11 abort.
        cfg_div = 16'd0;
        tx_q[tx_wr % 16] = 16'h00F0; tx_q[(tx_wr + 1) % 16] = 16'h000F; tx_wr = tx_wr + 2;
        wait_busy(1'b1);
        e0 = sclk_edges;
        repeat (40) @(negedge clk);
        chk("R6 zero divider no edges", sclk_edges - e0, 0);
        chk("R6 zero divider still busy", int'(busy), 1);
        en = 1'b0;
        @(negedge clk);
        chk("R11 busy cleared by disable", int'(busy), 0);
        chk("R11 selects released by disable", int'(ss_n), 15);
        chk("R11 sclk at rest after abort", int'(sclk), 0);
        chk("R11 tx fifo cleared", int'(tx_valid), 0);
        tx_q[tx_wr % 16] = 16'h0055; tx_wr = tx_wr + 1;
        repeat (5) @(negedge clk);
        chk("R11 no start while disabled", int'(busy), 0);
        cfg_div = 16'd2;
        en = 1'b1;
        repeat (3) @(negedge clk);
        chk("R11 idle after re-enable", int'(busy), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule